// File: doc/BRIEF.md
# Panel Power Sequencer

This block puts a flat-panel display's three enables in order: the panel supply rail, the video data output and the backlight. A single request to power on raises them one at a time in that order. A request to power off lowers them in the reverse order. Each pair of neighbouring steps is separated by a programmable wait, counted in strobes of a millisecond tick. There are two waits on the way up and two on the way down.

A power-off request that arrives while the panel is still coming up cuts the rise short. The block then walks down from whatever is enabled at that moment. A `busy` flag is high while a sequence is under way. A one-cycle `seq_done` pulse marks the arrival at either resting state.

Top module: `panel_power_seq`

## Requirements
- R1: During and after reset, `supply_en`, `video_en`, `bl_en`, `busy` and `seq_done` are all low, and the block rests in the fully-off state.
- R2: A `pwr_on_req` sampled high in the off state raises `supply_en` and `busy` on that same clock edge. `video_en` and `bl_en` stay low at that point.
- R3: `video_en` rises on the first clock edge after the tick that makes the count reach `dly_up_data`. Ticks are counted from the edge that raised `supply_en`.
- R4: `bl_en` rises on the first clock edge after the tick that makes the count reach `dly_up_light`. Ticks are counted from the edge that raised `video_en`. The backlight never rises while data is off.
- R5: A `pwr_off_req` sampled high in the fully-on state lowers `bl_en` on that edge. `video_en` and `supply_en` stay high at that point.
- R6: `video_en` falls on the first clock edge after the tick that makes the count reach `dly_dn_data`. Ticks are counted from the backlight-off edge. Data never falls while the backlight is on.
- R7: `supply_en` falls on the first clock edge after the tick that makes the count reach `dly_dn_supply`. Ticks are counted from the data-off edge. The supply never falls while data is on.
- R8: A wait programmed to zero lets the sequence take the following step on the next clock edge, with no tick needed.
- R9: A `pwr_off_req` during the rise aborts it. With only the supply on, the block goes straight to the supply-off wait (`dly_dn_supply`). With supply and data on, it goes to the data-off wait (`dly_dn_data`) and then continues as a normal power-down.
- R10: `busy` is high exactly while a wait step is in progress. `seq_done` is a one-cycle pulse on the edge that reaches fully on or fully off.
- R11: `pwr_on_req` has no effect while fully on or while powering down. `pwr_off_req` has no effect while fully off. If both requests are high in the off state, the block stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle strobe, once per millisecond |
| pwr_on_req | input | 1 | Request to power the panel up |
| pwr_off_req | input | 1 | Request to power the panel down |
| dly_up_data | input | 16 | Ticks from supply on to data on |
| dly_up_light | input | 16 | Ticks from data on to backlight on |
| dly_dn_data | input | 16 | Ticks from backlight off to data off |
| dly_dn_supply | input | 16 | Ticks from data off to supply off |
| supply_en | output | 1 | Panel supply rail enable |
| video_en | output | 1 | Video data output enable |
| bl_en | output | 1 | Backlight enable |
| busy | output | 1 | A sequence step is in progress |
| seq_done | output | 1 | Pulse on reaching fully on or fully off |

## Verification
Full up-and-down sequences are run with three delay sets.
- A set of small distinct values shows that each wait uses its own field. A swapped field moves an edge by a tick.
- An all-zero set shows the advance with no tick on every step.
- The typical 30/500/150/30 set checks that the counter does not wrap.

At each step the enables are sampled right after the last needed tick and again one clock later. This shows an edge that comes one tick early, or one that never comes.

Aborts are issued from each of the two rising steps, to tell apart the two re-entry points into the power-down. Requests that must be ignored are issued while on, while falling and while off, and the enables are checked after each one.

// File: rtl/psq_pkg.sv
// Package: shared state encoding for the panel power sequencer.
// Assumes: one state per resting level or per wait step.
package psq_pkg;

    typedef enum logic [2:0] {
        PS_OFF        = 3'd0,  // all enables low
        PS_UP_SUPPLY  = 3'd1,  // supply on, waiting to enable data
        PS_UP_DATA    = 3'd2,  // supply + data on, waiting for backlight
        PS_ON         = 3'd3,  // everything on
        PS_DN_LIGHT   = 3'd4,  // backlight off, waiting to drop data
        PS_DN_DATA    = 3'd5   // data off, waiting to drop supply
    } psq_state_e;

endpackage

// File: rtl/psq_interval_counter.sv
// Module: counts tick strobes since the last clear and reports when the
// count has reached a limit. The count saturates once the limit is reached.
// Assumes: clear has priority over tick; limit is held stable during a step.
module psq_interval_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             reached
);
    logic [CNT_W-1:0] count_q;

    // Compare combinationally so that a zero limit is reached at once.
    assign reached = (count_q >= limit);

    // Count ticks; restart on clear; hold once the limit is met.
    always_ff @(posedge clk) begin
        if (!rst_n)              count_q <= '0;
        else if (clear)          count_q <= '0;
        else if (tick && !reached) count_q <= count_q + 1'b1;
    end

    AST_CNT_NO_RUNAWAY: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !tick) |=> $stable(count_q)); // R3
endmodule

// File: rtl/psq_step_fsm.sv
// Module: step state machine of the sequencer. It picks the next step from
// the requests and the counter, and selects which wait limit is active.
// Assumes: requests are synchronous single-bit levels or pulses.
module psq_step_fsm
    import psq_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             on_req,
    input  logic             off_req,
    input  logic             wait_met,
    input  logic [DLY_W-1:0] dly_up_data,
    input  logic [DLY_W-1:0] dly_up_light,
    input  logic [DLY_W-1:0] dly_dn_data,
    input  logic [DLY_W-1:0] dly_dn_supply,
    output logic [DLY_W-1:0] wait_limit,
    output logic             step_clear,
    output psq_state_e       state_q,
    output psq_state_e       state_d
);
    // Next-step selection; an off request overrides the rise.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_OFF:       if (!off_req && on_req) state_d = PS_UP_SUPPLY;
            PS_UP_SUPPLY: if (off_req)            state_d = PS_DN_DATA;
                          else if (wait_met)      state_d = PS_UP_DATA;
            PS_UP_DATA:   if (off_req)            state_d = PS_DN_LIGHT;
                          else if (wait_met)      state_d = PS_ON;
            PS_ON:        if (off_req)            state_d = PS_DN_LIGHT;
            PS_DN_LIGHT:  if (wait_met)           state_d = PS_DN_DATA;
            PS_DN_DATA:   if (wait_met)           state_d = PS_OFF;
            default:                              state_d = PS_OFF;
        endcase
    end

    // Limit for the wait that belongs to the current step.
    always_comb begin
        unique case (state_q)
            PS_UP_SUPPLY: wait_limit = dly_up_data;
            PS_UP_DATA:   wait_limit = dly_up_light;
            PS_DN_LIGHT:  wait_limit = dly_dn_data;
            PS_DN_DATA:   wait_limit = dly_dn_supply;
            default:      wait_limit = '0;
        endcase
    end

    // The interval restarts on every step change.
    assign step_clear = (state_d != state_q);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_OFF;
        else        state_q <= state_d;
    end

    AST_ZERO_WAIT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_UP_SUPPLY && dly_up_data == '0 && !off_req)
        |=> (state_q == PS_UP_DATA)); // R8
    AST_ABORT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_UP_SUPPLY && off_req) |=> (state_q == PS_DN_DATA)); // R9
    AST_OFF_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_OFF && off_req) |=> (state_q == PS_OFF)); // R11
endmodule

// File: rtl/psq_rail_driver.sv
// Module: registers the pin-level enables and the status flags from the
// next step, so every output changes on the same edge as the state.
// Assumes: state_d and state_q come from the step machine.
module psq_rail_driver
    import psq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  psq_state_e state_q,
    input  psq_state_e state_d,
    output logic       supply_en,
    output logic       video_en,
    output logic       bl_en,
    output logic       busy,
    output logic       seq_done
);
    logic sup_n, vid_n, bl_n, busy_n, done_n;

    // Decode enables for the step being entered.
    always_comb begin
        sup_n  = (state_d != PS_OFF);
        vid_n  = (state_d == PS_UP_DATA) || (state_d == PS_ON) ||
                 (state_d == PS_DN_LIGHT);
        bl_n   = (state_d == PS_ON);
        busy_n = (state_d != PS_OFF) && (state_d != PS_ON);
        done_n = (state_q == PS_UP_DATA && state_d == PS_ON) ||
                 (state_q == PS_DN_DATA && state_d == PS_OFF);
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            supply_en <= 1'b0;
            video_en  <= 1'b0;
            bl_en     <= 1'b0;
            busy      <= 1'b0;
            seq_done  <= 1'b0;
        end else begin
            supply_en <= sup_n;
            video_en  <= vid_n;
            bl_en     <= bl_n;
            busy      <= busy_n;
            seq_done  <= done_n;
        end
    end

    AST_DATA_AFTER_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(video_en) |-> $past(supply_en)); // R2
    AST_LIGHT_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bl_en) |-> $past(video_en)); // R4
    AST_DATA_DROP_AFTER_LIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(video_en) |-> !$past(bl_en)); // R6
    AST_SUPPLY_DROP_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(supply_en) |-> !$past(video_en)); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done); // R10
endmodule

// File: rtl/panel_power_seq.sv
// Module: panel power sequencer top. It orders supply, data and backlight
// enables with four tick-counted waits. Power-down mirrors power-up.
// Assumes: ms_tick is a one-cycle strobe; wait fields are static per step.
module panel_power_seq
    import psq_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             pwr_on_req,
    input  logic             pwr_off_req,
    input  logic [DLY_W-1:0] dly_up_data,
    input  logic [DLY_W-1:0] dly_up_light,
    input  logic [DLY_W-1:0] dly_dn_data,
    input  logic [DLY_W-1:0] dly_dn_supply,
    output logic             supply_en,
    output logic             video_en,
    output logic             bl_en,
    output logic             busy,
    output logic             seq_done
);
    logic [DLY_W-1:0] wait_limit;
    logic             wait_met;
    logic             step_clear;
    psq_state_e       state_q;
    psq_state_e       state_d;

    psq_step_fsm #(.DLY_W(DLY_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .on_req       (pwr_on_req),
        .off_req      (pwr_off_req),
        .wait_met     (wait_met),
        .dly_up_data  (dly_up_data),
        .dly_up_light (dly_up_light),
        .dly_dn_data  (dly_dn_data),
        .dly_dn_supply(dly_dn_supply),
        .wait_limit   (wait_limit),
        .step_clear   (step_clear),
        .state_q      (state_q),
        .state_d      (state_d)
    );

    psq_interval_counter #(.CNT_W(DLY_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (step_clear),
        .tick   (ms_tick),
        .limit  (wait_limit),
        .reached(wait_met)
    );

    psq_rail_driver u_rails (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_q  (state_q),
        .state_d  (state_d),
        .supply_en(supply_en),
        .video_en (video_en),
        .bl_en    (bl_en),
        .busy     (busy),
        .seq_done (seq_done)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !(supply_en || video_en || bl_en || busy || seq_done)); // R1
    AST_ON_IGNORED_WHEN_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (bl_en && !pwr_off_req) |=> bl_en); // R11
endmodule

// File: tb/panel_power_seq_tb.sv
module panel_power_seq_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0, on_req = 1'b0, off_req = 1'b0;
    logic [15:0] d_ud = '0, d_ul = '0, d_dd = '0, d_ds = '0;
    logic supply_en, video_en, bl_en, busy, seq_done;
    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    panel_power_seq u_dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .pwr_on_req(on_req), .pwr_off_req(off_req),
        .dly_up_data(d_ud), .dly_up_light(d_ul),
        .dly_dn_data(d_dd), .dly_dn_supply(d_ds),
        .supply_en(supply_en), .video_en(video_en), .bl_en(bl_en),
        .busy(busy), .seq_done(seq_done)
    );

    // Compare {supply, video, backlight, busy, done} with the expected value.
    task automatic chk(string req, logic [4:0] exp);
        logic [4:0] act;
        act = {supply_en, video_en, bl_en, busy, seq_done};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic tick_n(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
        end
    endtask

    task automatic pulse_on();
        @(negedge clk) on_req = 1'b1;
        @(negedge clk) on_req = 1'b0;
    endtask

    task automatic pulse_off();
        @(negedge clk) off_req = 1'b1;
        @(negedge clk) off_req = 1'b0;
    endtask

    // Full rise, checking each edge right after its last tick and one clock later.
    task automatic run_up(int a, int b);
        d_ud = 16'(a); d_ul = 16'(b);
        pulse_on();
        chk("R2 supply first", 5'b10010);
        tick_n(a);
        chk("R3 data not early", 5'b10010);
        step();
        chk("R3 data on / R8", 5'b11010);
        tick_n(b);
        chk("R4 light not early", 5'b11010);
        step();
        chk("R4 light on, R10 done pulse", 5'b11101);
        step();
        chk("R10 done clears", 5'b11100);
    endtask

    task automatic run_down(int a, int b);
        d_dd = 16'(a); d_ds = 16'(b);
        pulse_off();
        chk("R5 light off first", 5'b11010);
        tick_n(a);
        chk("R6 data not early", 5'b11010);
        step();
        chk("R6 data off", 5'b10010);
        tick_n(b);
        chk("R7 supply not early", 5'b10010);
        step();
        chk("R7 supply off, R10 done", 5'b00001);
        step();
        chk("R10 idle", 5'b00000);
    endtask

    task automatic test_reset();
        repeat (3) step();
        chk("R1 in reset", 5'b00000);
        rst_n = 1'b1;
        step(); step();
        chk("R1 after reset", 5'b00000);
    endtask

    task automatic test_distinct();
        run_up(3, 2);
        run_down(4, 1);
    endtask

    task automatic test_zero();
        run_up(0, 0);   // R8
        run_down(0, 0); // R8
    endtask

    task automatic test_typical();
        run_up(30, 500);
        run_down(150, 30);
    endtask

    task automatic test_abort_supply();
        d_ud = 16'd5; d_ds = 16'd2;
        pulse_on();
        tick_n(2);
        pulse_off();
        chk("R9 abort keeps supply", 5'b10010);
        tick_n(2);
        chk("R9 supply held for wait", 5'b10010);
        step();
        chk("R9 supply off", 5'b00001);
        step();
    endtask

    task automatic test_abort_data();
        d_ud = 16'd0; d_ul = 16'd5; d_dd = 16'd2; d_ds = 16'd1;
        pulse_on();
        step();
        chk("R9 data up", 5'b11010);
        tick_n(1);
        pulse_off();
        chk("R9 abort keeps data", 5'b11010);
        tick_n(2);
        chk("R9 data held", 5'b11010);
        step();
        chk("R9 data off", 5'b10010);
        tick_n(1);
        step();
        chk("R9 supply off", 5'b00001);
        step();
    endtask

    task automatic test_ignored();
        pulse_off();
        chk("R11 off while off", 5'b00000);
        step();
        chk("R11 off while off later", 5'b00000);
        @(negedge clk) begin on_req = 1'b1; off_req = 1'b1; end
        @(negedge clk) begin on_req = 1'b0; off_req = 1'b0; end
        chk("R11 both requests in off", 5'b00000);
        run_up(1, 1);
        pulse_on();
        chk("R11 on while on", 5'b11100);
        d_dd = 16'd2; d_ds = 16'd1;
        pulse_off();
        pulse_on();
        chk("R11 on during power-down", 5'b11010);
        tick_n(2);
        step();
        chk("R11 power-down continues", 5'b10010);
        tick_n(1);
        step();
        chk("R11 reaches off", 5'b00001);
        step();
    endtask

    initial begin
        test_reset();
        test_distinct();
        test_zero();
        test_typical();
        test_abort_supply();
        test_abort_data();
        test_ignored();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule